// File: doc/BRIEF.md
# Framed Slave Poll Engine with Retransmission

This block runs one request/reply exchange with a remote board over a half-duplex byte link. When a request is accepted it builds a fixed-length frame: a start marker, one address byte, a block of payload bytes, and a closing CRC-8 byte. It hands the frame byte by byte to a transmitter through a valid/ready handshake. It then collects a reply of the same length from a receiver, one byte per valid pulse, and checks the reply's start marker and CRC.

A reply can be missing, cut short or corrupt. In each case the attempt counts as failed and the whole request frame is sent again, up to a bounded number of retries. When the exchange ends, a one-cycle done pulse reports the result: pass or fail, the number of failed attempts, and the bytes of the last reply received. The count and the reply bytes together form the error record for that board.

Top module: `slave_poll_ctrl`

## Requirements
- R1: After reset, `req_ready_o` is 1, `tx_valid_o` is 0, `done_o` is 0 and `fail_cnt_o` is 0.
- R2: A request frame has FRAME_BYTES (28) bytes, sent in this order:
  - byte 0 is 0x40;
  - byte 1 is `req_addr_i`;
  - byte k+2 is `req_payload_i[8k+7:8k]`;
  - the last byte is a CRC-8 with polynomial 0x07 and initial value 0xFF, computed MSB first with no final inversion, over every byte before it.
- R3: A frame byte moves on only when `tx_valid_o` and `tx_ready_i` are both high. While `tx_ready_i` is low, `tx_valid_o` stays high and `tx_data_o` does not change.
- R4: A request is taken only when `req_valid_i` is high while `req_ready_o` is high. A request offered while an exchange is running changes neither the frame being sent nor the number of exchanges.
- R5: A good reply has FRAME_BYTES bytes, byte 0 equal to 0x40, and a last byte equal to the R2 CRC of the bytes before it. A good reply ends the exchange with `done_o` high, `fail_o` 0, and `fail_cnt_o` equal to the number of attempts that failed before it. `rsp_data_o[8i+7:8i]` holds reply byte i.
- R6: An attempt fails when TIMEOUT_CYC cycles pass with no reply byte. The count starts at the handshake of the last request byte and starts again at every reply byte. The retransmission starts again from byte 0 with the same content.
- R7: A complete reply with a wrong start byte or a wrong CRC counts as a failed attempt, the same as a timeout, and causes a retransmission.
- R8: After MAX_RETRY+1 (3) failed attempts, `done_o` rises with `fail_o` 1 and `fail_cnt_o` equal to MAX_RETRY+1. No further byte is transmitted.
- R9: Bytes on `rx_valid_i` that arrive while no reply is awaited (while idle or while sending) are discarded. They do not affect the next reply.
- R10: `done_o` is high for exactly one cycle, and `req_ready_o` is 1 in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe |
| req_ready_o | output | 1 | Engine idle, request can be taken |
| req_addr_i | input | 8 | Target board address byte |
| req_payload_i | input | (FRAME_BYTES-3)*8 | Payload bytes, byte k in bits 8k+7:8k |
| tx_valid_o | output | 1 | Byte offered to transmitter |
| tx_ready_i | input | 1 | Transmitter takes byte |
| tx_data_o | output | 8 | Byte to transmit |
| rx_valid_i | input | 1 | Received byte strobe |
| rx_data_i | input | 8 | Received byte |
| done_o | output | 1 | Exchange finished, one cycle |
| fail_o | output | 1 | Last exchange exhausted all attempts |
| fail_cnt_o | output | $clog2(MAX_RETRY+2) | Failed attempts in last exchange |
| rsp_data_o | output | FRAME_BYTES*8 | Last reply bytes, byte i in bits 8i+7:8i |

## Verification
The hardest case to reach is a reply that arrives slowly enough to take most of the timeout window per byte but never all of it. There, the silence counter must restart on every byte rather than measure the whole reply. The bench sends a good reply with gaps of TIMEOUT_CYC-8 cycles between byte strobes. It expects success with zero failures. It also sends a truncated reply followed by silence, and expects the retransmission to appear one timeout after the last partial byte. Exhausting all attempts takes three full silent windows, so the bench uses a short TIMEOUT_CYC.

// File: rtl/spc_pkg.sv
package spc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_WAIT = 2'd2
  } spc_state_e;
endpackage

// File: rtl/spc_crc8.sv
module spc_crc8 #(
  parameter logic [7:0] POLY = 8'h07
) (
  input  logic [7:0] crc_i,
  input  logic [7:0] data_i,
  output logic [7:0] crc_o
);
  logic [7:0] c;
  always_comb begin
    c = crc_i ^ data_i;
    for (int b = 0; b < 8; b++) begin
      c = c[7] ? ((c << 1) ^ POLY) : (c << 1);
    end
    crc_o = c;
  end
endmodule

// File: rtl/spc_timeout.sv
module spc_timeout #(
  parameter int unsigned LIMIT = 100000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic clr_i,
  output logic expired_o
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST_CNT = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (!run_i || clr_i)    cnt_q <= '0;
    else if (cnt_q != LAST_CNT)  cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = run_i && !clr_i && (cnt_q == LAST_CNT);

  // R6: silence counter never passes its limit
  a_r6_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST_CNT);
endmodule

// File: rtl/spc_rx_collect.sv
module spc_rx_collect #(
  parameter int unsigned FRAME_BYTES = 28,
  parameter logic [7:0]  START_BYTE  = 8'h40,
  parameter logic [7:0]  CRC_POLY    = 8'h07,
  parameter logic [7:0]  CRC_INIT    = 8'hFF
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     en_i,
  input  logic                     rx_valid_i,
  input  logic [7:0]               rx_data_i,
  output logic [FRAME_BYTES*8-1:0] frame_o,
  output logic                     done_o,
  output logic                     ok_o
);
  localparam int unsigned IDX_W = $clog2(FRAME_BYTES + 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BYTES - 1);
  localparam logic [IDX_W-1:0] FULL_IDX = IDX_W'(FRAME_BYTES);

  logic [IDX_W-1:0]         idx_q;
  logic [7:0]               crc_q, crc_nxt;
  logic                     hdr_ok_q, done_q, ok_q;
  logic [FRAME_BYTES*8-1:0] frame_q;

  spc_crc8 #(.POLY(CRC_POLY)) u_crc (
    .crc_i (crc_q),
    .data_i(rx_data_i),
    .crc_o (crc_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q    <= '0;
      crc_q    <= CRC_INIT;
      hdr_ok_q <= 1'b0;
      done_q   <= 1'b0;
      ok_q     <= 1'b0;
      frame_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (!en_i) begin
        // out-of-window bytes are dropped; each attempt starts clean
        idx_q <= '0;
        crc_q <= CRC_INIT;
      end else if (rx_valid_i && idx_q != FULL_IDX) begin
        frame_q[{idx_q, 3'b000} +: 8] <= rx_data_i;
        if (idx_q == '0) hdr_ok_q <= (rx_data_i == START_BYTE);
        if (idx_q == LAST_IDX) begin
          done_q <= 1'b1;
          ok_q   <= hdr_ok_q && (rx_data_i == crc_q);
        end else begin
          crc_q <= crc_nxt;
        end
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  assign frame_o = frame_q;
  assign done_o  = done_q;
  assign ok_o    = ok_q;

  // R5: byte index stays within one frame
  a_r5_idx_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_q <= FULL_IDX);
  // R5: completion is flagged only once the full frame is held
  a_r5_done_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> idx_q == FULL_IDX);
endmodule

// File: rtl/slave_poll_ctrl.sv
module slave_poll_ctrl
  import spc_pkg::*;
#(
  parameter int unsigned FRAME_BYTES = 28,
  parameter int unsigned TIMEOUT_CYC = 100000,
  parameter int unsigned MAX_RETRY   = 2,
  parameter logic [7:0]  START_BYTE  = 8'h40,
  parameter logic [7:0]  CRC_POLY    = 8'h07,
  parameter logic [7:0]  CRC_INIT    = 8'hFF,
  localparam int unsigned PAY_W = (FRAME_BYTES - 3) * 8,
  localparam int unsigned CNT_W = $clog2(MAX_RETRY + 2)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     req_valid_i,
  output logic                     req_ready_o,
  input  logic [7:0]               req_addr_i,
  input  logic [PAY_W-1:0]         req_payload_i,
  output logic                     tx_valid_o,
  input  logic                     tx_ready_i,
  output logic [7:0]               tx_data_o,
  input  logic                     rx_valid_i,
  input  logic [7:0]               rx_data_i,
  output logic                     done_o,
  output logic                     fail_o,
  output logic [CNT_W-1:0]         fail_cnt_o,
  output logic [FRAME_BYTES*8-1:0] rsp_data_o
);
  localparam int unsigned PAY_BYTES = FRAME_BYTES - 3;
  localparam int unsigned IDX_W     = $clog2(FRAME_BYTES + 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BYTES - 1);
  localparam logic [CNT_W-1:0] MAX_FAIL = CNT_W'(MAX_RETRY);
  localparam logic [CNT_W-1:0] ALL_FAIL = CNT_W'(MAX_RETRY + 1);

  spc_state_e       state_q;
  logic [7:0]       frame_q [FRAME_BYTES-1];
  logic [IDX_W-1:0] tx_idx_q, sel_idx;
  logic [7:0]       tx_crc_q, tx_crc_nxt;
  logic [CNT_W-1:0] fails_q;
  logic             done_q, fail_q;
  logic             rx_done, rx_ok, expired;
  logic             attempt_bad;

  assign sel_idx = (tx_idx_q == LAST_IDX) ? '0 : tx_idx_q;

  spc_crc8 #(.POLY(CRC_POLY)) u_tx_crc (
    .crc_i (tx_crc_q),
    .data_i(frame_q[sel_idx]),
    .crc_o (tx_crc_nxt)
  );

  spc_rx_collect #(
    .FRAME_BYTES(FRAME_BYTES),
    .START_BYTE (START_BYTE),
    .CRC_POLY   (CRC_POLY),
    .CRC_INIT   (CRC_INIT)
  ) u_rx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (state_q == ST_WAIT),
    .rx_valid_i(rx_valid_i),
    .rx_data_i (rx_data_i),
    .frame_o   (rsp_data_o),
    .done_o    (rx_done),
    .ok_o      (rx_ok)
  );

  spc_timeout #(.LIMIT(TIMEOUT_CYC)) u_tmo (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (state_q == ST_WAIT),
    .clr_i    (rx_valid_i),
    .expired_o(expired)
  );

  assign attempt_bad = (rx_done && !rx_ok) || (!rx_done && expired);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      tx_idx_q <= '0;
      tx_crc_q <= CRC_INIT;
      fails_q  <= '0;
      done_q   <= 1'b0;
      fail_q   <= 1'b0;
      for (int k = 0; k < FRAME_BYTES - 1; k++) frame_q[k] <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          frame_q[0] <= START_BYTE;
          frame_q[1] <= req_addr_i;
          for (int k = 0; k < PAY_BYTES; k++) frame_q[k+2] <= req_payload_i[k*8 +: 8];
          tx_idx_q <= '0;
          tx_crc_q <= CRC_INIT;
          fails_q  <= '0;
          state_q  <= ST_SEND;
        end
        ST_SEND: if (tx_ready_i) begin
          if (tx_idx_q == LAST_IDX) begin
            state_q <= ST_WAIT;
          end else begin
            tx_crc_q <= tx_crc_nxt;
            tx_idx_q <= tx_idx_q + 1'b1;
          end
        end
        ST_WAIT: begin
          if (rx_done && rx_ok) begin
            done_q  <= 1'b1;
            fail_q  <= 1'b0;
            state_q <= ST_IDLE;
          end else if (attempt_bad) begin
            fails_q <= fails_q + 1'b1;
            if (fails_q == MAX_FAIL) begin
              done_q  <= 1'b1;
              fail_q  <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              tx_idx_q <= '0;
              tx_crc_q <= CRC_INIT;
              state_q  <= ST_SEND;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o = (state_q == ST_IDLE);
  assign tx_valid_o  = (state_q == ST_SEND);
  assign tx_data_o   = (tx_idx_q == LAST_IDX) ? tx_crc_q : frame_q[sel_idx];
  assign done_o      = done_q;
  assign fail_o      = fail_q;
  assign fail_cnt_o  = fails_q;

  // R4: never accepting and sending at once
  a_r4_ready_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_ready_o && tx_valid_o));
  // R3: offered byte held until taken
  a_r3_tx_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_data_o));
  // R2: every attempt opens with the start marker
  a_r2_first_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_valid_o) |-> tx_data_o == START_BYTE);
  // R10: done is a single-cycle pulse
  a_r10_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R8: a failed exchange reports every attempt as failed
  a_r8_fail_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && fail_o |-> fail_cnt_o == ALL_FAIL);
  // R8: failure count bounded
  a_r8_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_cnt_o <= ALL_FAIL);
endmodule

// File: tb/slave_poll_ctrl_tb.sv
module slave_poll_ctrl_tb;
  localparam int FB = 28;
  localparam int T  = 200;
  localparam int MR = 2;
  localparam int PAY_W = (FB - 3) * 8;
  localparam int CW = $clog2(MR + 2);

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic req_valid_i = 1'b0, req_ready_o;
  logic [7:0] req_addr_i = '0;
  logic [PAY_W-1:0] req_payload_i = '0;
  logic tx_valid_o, tx_ready_i = 1'b0;
  logic [7:0] tx_data_o;
  logic rx_valid_i = 1'b0;
  logic [7:0] rx_data_i = '0;
  logic done_o, fail_o;
  logic [CW-1:0] fail_cnt_o;
  logic [FB*8-1:0] rsp_data_o;

  int checks = 0, errors = 0;
  logic [7:0] txf [FB];
  logic [7:0] rxf [FB];

  always #10 clk = ~clk;

  slave_poll_ctrl #(.FRAME_BYTES(FB), .TIMEOUT_CYC(T), .MAX_RETRY(MR)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
    .req_addr_i(req_addr_i), .req_payload_i(req_payload_i),
    .tx_valid_o(tx_valid_o), .tx_ready_i(tx_ready_i), .tx_data_o(tx_data_o),
    .rx_valid_i(rx_valid_i), .rx_data_i(rx_data_i),
    .done_o(done_o), .fail_o(fail_o), .fail_cnt_o(fail_cnt_o),
    .rsp_data_o(rsp_data_o)
  );

  function automatic logic [7:0] crc_step(input logic [7:0] c, input logic [7:0] b);
    logic [7:0] r;
    r = c ^ b;
    for (int i = 0; i < 8; i++) r = r[7] ? ((r << 1) ^ 8'h07) : (r << 1);
    return r;
  endfunction

  function automatic logic [PAY_W-1:0] mk_pay(input logic [7:0] seed);
    logic [PAY_W-1:0] p;
    for (int k = 0; k < FB - 3; k++) p[k*8 +: 8] = seed + 8'(k * 13);
    return p;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [7:0] addr, input logic [PAY_W-1:0] pay);
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk);
      if (req_ready_o) break;
    end
    req_valid_i = 1'b1; req_addr_i = addr; req_payload_i = pay;
    @(negedge clk);
    req_valid_i = 1'b0;
  endtask

  // collects one frame; stall toggles ready every other cycle (R3)
  task automatic get_frame(input bit stall);
    int got;
    bit held;
    logic [7:0] hv;
    got = 0; held = 0; hv = '0;
    for (int cyc = 0; cyc < 2000 && got < FB; cyc++) begin
      @(negedge clk);
      if (held) chk(tx_valid_o && tx_data_o == hv, "R3 held byte", {24'd0, tx_data_o}, {24'd0, hv});
      tx_ready_i = stall ? cyc[0] : 1'b1;
      held = tx_valid_o && !tx_ready_i;
      hv = tx_data_o;
      if (tx_valid_o && tx_ready_i) begin
        txf[got] = tx_data_o;
        got++;
      end
    end
    chk(got == FB, "R2 byte count", got, FB);
    @(negedge clk);
    tx_ready_i = 1'b0;
  endtask

  task automatic check_frame(input logic [7:0] addr, input logic [PAY_W-1:0] pay);
    int bad;
    logic [7:0] c;
    bad = 0; c = 8'hFF;
    if (txf[0] != 8'h40) bad++;
    if (txf[1] != addr) bad++;
    for (int k = 0; k < FB - 3; k++) if (txf[k+2] != pay[k*8 +: 8]) bad++;
    for (int k = 0; k < FB - 1; k++) c = crc_step(c, txf[k]);
    chk(txf[FB-1] == c, "R2 crc byte", {24'd0, txf[FB-1]}, {24'd0, c});
    chk(bad == 0, "R2 frame content mismatches", bad, 0);
  endtask

  // mode 0 good, 1 bad crc, 2 bad start byte
  task automatic make_reply(input logic [7:0] seed, input int mode);
    logic [7:0] c;
    rxf[0] = (mode == 2) ? 8'h41 : 8'h40;
    for (int k = 1; k < FB - 1; k++) rxf[k] = seed ^ 8'(k * 29);
    c = 8'hFF;
    for (int k = 0; k < FB - 1; k++) c = crc_step(c, rxf[k]);
    rxf[FB-1] = (mode == 1) ? (c ^ 8'h01) : c;
  endtask

  task automatic send_reply(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rx_valid_i = 1'b1; rx_data_i = rxf[i];
      @(negedge clk);
      rx_valid_i = 1'b0;
      if (i != n - 1) repeat (gap) @(negedge clk);
    end
  endtask

  task automatic wait_done(input int lim, input bit exp_fail, input int exp_cnt, input string tag);
    bit seen;
    seen = 0;
    for (int i = 0; i < lim; i++) begin
      @(negedge clk);
      if (done_o) begin seen = 1; break; end
    end
    chk(seen, {tag, " done seen"}, seen, 1);
    if (seen) begin
      chk(fail_o == exp_fail, {tag, " fail flag"}, fail_o, exp_fail);
      chk(fail_cnt_o == exp_cnt, {tag, " fail count"}, fail_cnt_o, exp_cnt);
      chk(req_ready_o, "R10 ready with done", req_ready_o, 1);
      @(negedge clk);
      chk(!done_o, "R10 single-cycle done", done_o, 0);
    end
  endtask

  task automatic check_rsp(input string tag);
    int bad;
    bad = 0;
    for (int k = 0; k < FB; k++) if (rsp_data_o[k*8 +: 8] != rxf[k]) bad++;
    chk(bad == 0, tag, bad, 0);
  endtask

  task automatic measure_gap(output int k);
    k = 0;
    tx_ready_i = 1'b0;
    for (int i = 0; i < T + 50; i++) begin
      @(negedge clk);
      k++;
      if (tx_valid_o) break;
    end
  endtask

  task automatic no_tx(input int n, input string tag);
    int seen;
    seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (tx_valid_o) seen++;
    end
    chk(seen == 0, tag, seen, 0);
  endtask

  task automatic t_reset;
    rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(req_ready_o == 1'b1, "R1 ready", req_ready_o, 1);
    chk(tx_valid_o == 1'b0, "R1 tx idle", tx_valid_o, 0);
    chk(done_o == 1'b0, "R1 done low", done_o, 0);
    chk(fail_cnt_o == '0, "R1 count zero", fail_cnt_o, 0);
  endtask

  task automatic t_basic;
    issue(8'h15, mk_pay(8'h03));
    get_frame(1'b1);
    check_frame(8'h15, mk_pay(8'h03));
    make_reply(8'h33, 0);
    send_reply(FB, 0);
    wait_done(50, 1'b0, 0, "R5 good reply");
    check_rsp("R5 reply bytes");
  endtask

  task automatic t_busy;
    issue(8'h22, mk_pay(8'h10));
    fork
      get_frame(1'b0);
      begin
        repeat (6) @(negedge clk);
        req_valid_i = 1'b1; req_addr_i = 8'h77; req_payload_i = mk_pay(8'h99);
        @(negedge clk);
        req_valid_i = 1'b0;
      end
    join
    check_frame(8'h22, mk_pay(8'h10));
    @(negedge clk);
    req_valid_i = 1'b1; req_addr_i = 8'h78;
    @(negedge clk);
    req_valid_i = 1'b0;
    make_reply(8'h44, 0);
    send_reply(FB, 0);
    wait_done(50, 1'b0, 0, "R4 busy request");
    no_tx(3 * T, "R4 no extra exchange");
  endtask

  task automatic t_timeout;
    int k;
    issue(8'h31, mk_pay(8'h20));
    get_frame(1'b0);
    measure_gap(k);
    chk(k >= T - 1 && k <= T + 1, "R6 silence window", k, T);
    get_frame(1'b0);
    check_frame(8'h31, mk_pay(8'h20));
    make_reply(8'h55, 0);
    send_reply(10, 0);
    measure_gap(k);
    chk(k >= T - 1 && k <= T + 1, "R6 window after partial reply", k, T);
    get_frame(1'b0);
    check_frame(8'h31, mk_pay(8'h20));
    send_reply(FB, 0);
    wait_done(50, 1'b0, 2, "R6 success after timeouts");
  endtask

  task automatic t_bad;
    int k;
    issue(8'h42, mk_pay(8'h30));
    get_frame(1'b0);
    make_reply(8'h66, 1);
    send_reply(FB, 0);
    measure_gap(k);
    chk(k < T / 2, "R7 bad crc resend", k, 0);
    get_frame(1'b0);
    check_frame(8'h42, mk_pay(8'h30));
    make_reply(8'h66, 2);
    send_reply(FB, 0);
    get_frame(1'b0);
    check_frame(8'h42, mk_pay(8'h30));
    make_reply(8'h67, 0);
    send_reply(FB, 0);
    wait_done(50, 1'b0, 2, "R7 bad replies counted");
    check_rsp("R7 reply bytes");
  endtask

  task automatic t_exhaust;
    issue(8'h53, mk_pay(8'h40));
    get_frame(1'b0);
    get_frame(1'b0);
    get_frame(1'b0);
    wait_done(T + 50, 1'b1, MR + 1, "R8 exhausted");
    no_tx(3 * T, "R8 no transmission after failure");
  endtask

  task automatic t_rx_ignore;
    make_reply(8'h11, 1);
    send_reply(5, 0);
    issue(8'h64, mk_pay(8'h50));
    fork
      get_frame(1'b1);
      begin
        repeat (4) @(negedge clk);
        for (int i = 0; i < 10; i++) begin
          @(negedge clk);
          rx_valid_i = 1'b1; rx_data_i = 8'hA5;
        end
        @(negedge clk);
        rx_valid_i = 1'b0;
      end
    join
    make_reply(8'h77, 0);
    send_reply(FB, 0);
    wait_done(50, 1'b0, 0, "R9 stray bytes ignored");
    check_rsp("R9 reply bytes");
  endtask

  task automatic t_trickle;
    issue(8'h75, mk_pay(8'h60));
    get_frame(1'b0);
    make_reply(8'h88, 0);
    send_reply(FB, T - 10);
    wait_done(50, 1'b0, 0, "R6 slow reply kept alive");
    check_rsp("R6 slow reply bytes");
  endtask

  initial begin
    t_reset();
    t_basic();
    t_busy();
    t_timeout();
    t_bad();
    t_exhaust();
    t_rx_ignore();
    t_trickle();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule